// File: doc/BRIEF.md
# CRC-Checked Retransmitting Neighbour Link

This block holds both ends of a point-to-point link that carries a block of wide data words from one node into the receive queue of a neighbouring node. Local computation keeps running while the transfer is in progress. The sending side takes a block command with a word count. It pulls the words one at a time from a word stream. Each word goes out as its own packet on a byte-wide lane, one byte per clock. A packet is a start marker, then the word's bytes, then a 16-bit checksum.

The receiving side aligns on the marker and recomputes the checksum. A packet whose checksum matches is pushed into the local queue and acknowledged on a 2-bit reverse lane. A packet whose checksum does not match is discarded and refused. The sender keeps the word until an answer arrives. On a refusal it sends the same packet again. On an acknowledge it moves on to the next word.

The reverse lane also carries a ready code. The receiver shows this code only while its node has enabled reception and no packet is being collected. A sender that runs ahead of its receiver therefore stalls until the receiver catches up. The word width and the count width are parameters. A node instantiates one such block per neighbour and wires the lanes to the neighbour's block.

Top module: `link_point`

## Requirements
- R1: Reset is synchronous and active high. During reset and in the first cycle after it, the following outputs are low: tx_lane_valid, push_valid, done and wd_ready. rx_back_out reads 0 (idle) while rx_en is low.
- R2: A packet occupies the lane for DATA_W/8+3 consecutive cycles with tx_lane_valid high: 19 cycles at the default width. The bytes go out in this order:
  - first the start marker 0xA5;
  - then the data bytes, most significant byte first;
  - then the checksum, high byte first.
- R3: The checksum is the CRC with polynomial 0x1021 and initial value 0xFFFF. It is computed MSB-first over the data bytes only, with no reflection and no final inversion.
- R4: The packets are stop-and-wait. After a packet, the sender waits for the reverse lane to show code 1 (ACK) or code 2 (NAK). On NAK it resends the same word. On ACK it moves to the next word.
- R5: The sender starts a packet only in the cycle after it has seen code 3 (READY) on the reverse lane. The receiver shows READY only while rx_en is high and it is not collecting a packet. While rx_en stays low, no packet starts.
- R6: The receiver raises push_valid for one cycle with the packet's word only when the received checksum matches, and in that cycle the reverse lane shows ACK. When the checksum does not match, the receiver drops the word, shows NAK and does not push.
- R7: The words of a block reach the push port exactly once each and in the order in which they were fetched, whatever retransmissions take place.
- R8: done clears on the clock edge that accepts cmd_start when cmd_len is non-zero. It rises after the last word of the block has been acknowledged. A block of length 0 sets done on the edge that accepts the command.
- R9: wd_ready is high only while the sender waits for its next word. Exactly one word is taken from the stream per block word, and a retransmission takes no new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | One-cycle pulse that starts a block transfer (accepted when idle) |
| cmd_len | input | LEN_W | Number of words in the block |
| wd_valid | input | 1 | Word stream has a word available |
| wd_data | input | DATA_W | Next word of the block |
| wd_ready | output | 1 | Sender takes wd_data on this edge when wd_valid is high |
| done | output | 1 | Every word of the last block has been acknowledged |
| tx_lane_valid | output | 1 | Outgoing lane carries a packet byte |
| tx_lane_byte | output | 8 | Outgoing lane byte |
| tx_back_in | input | 2 | Reverse lane from the far receiver: 0 idle, 1 ACK, 2 NAK, 3 READY |
| rx_en | input | 1 | Local node enables reception on this link |
| rx_lane_valid | input | 1 | Incoming lane carries a packet byte |
| rx_lane_byte | input | 8 | Incoming lane byte |
| rx_back_out | output | 2 | Reverse lane to the far sender, same coding as tx_back_in |
| push_valid | output | 1 | One-cycle push of a good word into the receive queue |
| push_data | output | DATA_W | Word being pushed |

## Verification
The assertions check four rules on every cycle:
- every packet begins with the marker, and only after a READY;
- a word held across a NAK does not change;
- a push never appears without an ACK beside it;
- READY is never shown unless reception was enabled.

Some behaviours only the bench's scenarios can show. These are the checksum value on the lane, the in-order and exactly-once delivery across random corruptions, the count of NAKs against the corruptions injected, and the stall while reception is disabled. The bench covers them with random blocks, random reception toggling, a forced checksum-byte corruption and a zero-length block.

// File: rtl/link_pkg.sv
package link_pkg;
  localparam logic [1:0] BK_IDLE  = 2'd0;
  localparam logic [1:0] BK_ACK   = 2'd1;
  localparam logic [1:0] BK_NAK   = 2'd2;
  localparam logic [1:0] BK_READY = 2'd3;

  localparam logic [7:0]  PKT_MARK = 8'hA5;
  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_INIT = 16'hFFFF;

  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ d[i]) r = (r << 1) ^ CRC_POLY;
      else              r = r << 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/link_tx.sv
module link_tx
  import link_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_start,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              wd_valid,
  input  logic [DATA_W-1:0] wd_data,
  output logic              wd_ready,
  output logic              done,
  output logic              lane_valid,
  output logic [7:0]        lane_byte,
  input  logic [1:0]        back_in
);
  localparam int NBYTES = DATA_W / 8;
  localparam int IDX_W  = $clog2(NBYTES + 3);
  localparam logic [IDX_W-1:0] IDX_CRC_HI = IDX_W'(NBYTES);
  localparam logic [IDX_W-1:0] IDX_CRC_LO = IDX_W'(NBYTES + 1);
  localparam logic [IDX_W-1:0] IDX_END    = IDX_W'(NBYTES + 2);

  typedef enum logic [2:0] {ST_IDLE, ST_LOAD, ST_WAITR, ST_SEND, ST_RESP} tx_state_e;

  tx_state_e         state;
  logic [LEN_W-1:0]  remain;
  logic [DATA_W-1:0] word_q;
  logic [DATA_W-1:0] shift_q;
  logic [IDX_W-1:0]  idx;
  logic [15:0]       crc;

  assign wd_ready = (state == ST_LOAD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      remain     <= '0;
      word_q     <= '0;
      shift_q    <= '0;
      idx        <= '0;
      crc        <= CRC_INIT;
      done       <= 1'b0;
      lane_valid <= 1'b0;
      lane_byte  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (cmd_start) begin
          if (cmd_len == '0) begin
            done <= 1'b1;
          end else begin
            done   <= 1'b0;
            remain <= cmd_len;
            state  <= ST_LOAD;
          end
        end
        ST_LOAD: if (wd_valid) begin
          word_q <= wd_data;
          state  <= ST_WAITR;
        end
        ST_WAITR: if (back_in == BK_READY) begin
          lane_valid <= 1'b1;
          lane_byte  <= PKT_MARK;
          shift_q    <= word_q;
          crc        <= CRC_INIT;
          idx        <= '0;
          state      <= ST_SEND;
        end
        ST_SEND: begin
          if (idx < IDX_CRC_HI) begin
            lane_byte <= shift_q[DATA_W-1 -: 8];
            shift_q   <= shift_q << 8;
            crc       <= crc16_step(crc, shift_q[DATA_W-1 -: 8]);
            idx       <= idx + 1'b1;
          end else if (idx == IDX_CRC_HI) begin
            lane_byte <= crc[15:8];
            idx       <= idx + 1'b1;
          end else if (idx == IDX_CRC_LO) begin
            lane_byte <= crc[7:0];
            idx       <= idx + 1'b1;
          end else begin
            lane_valid <= 1'b0;
            state      <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (back_in == BK_ACK) begin
            remain <= remain - 1'b1;
            if (remain == LEN_W'(1)) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              state <= ST_LOAD;
            end
          end else if (back_in == BK_NAK) begin
            state <= ST_WAITR;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_MARK_LEADS: assert property (@(posedge clk) disable iff (rst)
    $rose(lane_valid) |-> lane_byte == PKT_MARK); // R2
  AST_READY_BEFORE_SEND: assert property (@(posedge clk) disable iff (rst)
    $rose(lane_valid) |-> $past(back_in) == BK_READY); // R5
  AST_RETRY_SAME_WORD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RESP && back_in == BK_NAK) |=> $stable(word_q)); // R4
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    done |-> (!lane_valid && !wd_ready)); // R8
  AST_LANE_SPAN: assert property (@(posedge clk) disable iff (rst)
    $fell(lane_valid) |-> $past(idx) == IDX_END); // R2
endmodule

// File: rtl/link_rx.sv
module link_rx
  import link_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              lane_valid,
  input  logic [7:0]        lane_byte,
  output logic [1:0]        back_out,
  output logic              push_valid,
  output logic [DATA_W-1:0] push_data
);
  localparam int NBYTES = DATA_W / 8;
  localparam int CNT_W  = $clog2(NBYTES + 2);
  localparam logic [CNT_W-1:0] CNT_CRC_HI = CNT_W'(NBYTES);

  typedef enum logic {RS_HUNT, RS_COLLECT} rx_state_e;

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [15:0]       crc;
  logic [7:0]        crc_hi;
  logic [DATA_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= RS_HUNT;
      cnt        <= '0;
      crc        <= CRC_INIT;
      crc_hi     <= '0;
      word_q     <= '0;
      back_out   <= BK_IDLE;
      push_valid <= 1'b0;
      push_data  <= '0;
    end else begin
      push_valid <= 1'b0;
      case (state)
        RS_HUNT: begin
          back_out <= rx_en ? BK_READY : BK_IDLE;
          if (lane_valid && lane_byte == PKT_MARK) begin
            back_out <= BK_IDLE;
            cnt      <= '0;
            crc      <= CRC_INIT;
            state    <= RS_COLLECT;
          end
        end
        RS_COLLECT: begin
          back_out <= BK_IDLE;
          if (lane_valid) begin
            if (cnt < CNT_CRC_HI) begin
              word_q <= {word_q[DATA_W-9:0], lane_byte};
              crc    <= crc16_step(crc, lane_byte);
              cnt    <= cnt + 1'b1;
            end else if (cnt == CNT_CRC_HI) begin
              crc_hi <= lane_byte;
              cnt    <= cnt + 1'b1;
            end else begin
              if ({crc_hi, lane_byte} == crc) begin
                push_valid <= 1'b1;
                push_data  <= word_q;
                back_out   <= BK_ACK;
              end else begin
                back_out   <= BK_NAK;
              end
              state <= RS_HUNT;
            end
          end
        end
        default: state <= RS_HUNT;
      endcase
    end
  end

  AST_PUSH_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
    push_valid |-> back_out == BK_ACK); // R6
  AST_NAK_NO_PUSH: assert property (@(posedge clk) disable iff (rst)
    (back_out == BK_NAK) |-> !push_valid); // R6
  AST_READY_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    (back_out == BK_READY) |-> $past(rx_en)); // R5
endmodule

// File: rtl/link_point.sv
module link_point
  import link_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_start,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              wd_valid,
  input  logic [DATA_W-1:0] wd_data,
  output logic              wd_ready,
  output logic              done,
  output logic              tx_lane_valid,
  output logic [7:0]        tx_lane_byte,
  input  logic [1:0]        tx_back_in,
  input  logic              rx_en,
  input  logic              rx_lane_valid,
  input  logic [7:0]        rx_lane_byte,
  output logic [1:0]        rx_back_out,
  output logic              push_valid,
  output logic [DATA_W-1:0] push_data
);
  link_tx #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .cmd_start  (cmd_start),
    .cmd_len    (cmd_len),
    .wd_valid   (wd_valid),
    .wd_data    (wd_data),
    .wd_ready   (wd_ready),
    .done       (done),
    .lane_valid (tx_lane_valid),
    .lane_byte  (tx_lane_byte),
    .back_in    (tx_back_in)
  );

  link_rx #(.DATA_W(DATA_W)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .rx_en      (rx_en),
    .lane_valid (rx_lane_valid),
    .lane_byte  (rx_lane_byte),
    .back_out   (rx_back_out),
    .push_valid (push_valid),
    .push_data  (push_data)
  );
endmodule

// File: tb/test_link_point.sv
module test_link_point;
  localparam int DATA_W = 128;
  localparam int LEN_W  = 16;
  localparam int NB     = DATA_W / 8;
  localparam int PKT    = NB + 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cmd_start = 1'b0;
  logic [LEN_W-1:0]  cmd_len = '0;
  logic              wd_valid = 1'b1;
  logic [DATA_W-1:0] wd_data = '0;
  logic              wd_ready, done;
  logic              tx_lane_valid;
  logic [7:0]        tx_lane_byte;
  logic              rx_en = 1'b0;
  logic [7:0]        flip = '0;
  logic [7:0]        rx_lane_byte;
  logic [1:0]        rx_back_out;
  logic              push_valid;
  logic [DATA_W-1:0] push_data;

  assign rx_lane_byte = tx_lane_byte ^ flip;

  link_point #(.DATA_W(DATA_W), .LEN_W(LEN_W)) i_link_point (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_len(cmd_len),
    .wd_valid(wd_valid), .wd_data(wd_data), .wd_ready(wd_ready), .done(done),
    .tx_lane_valid(tx_lane_valid), .tx_lane_byte(tx_lane_byte),
    .tx_back_in(rx_back_out), .rx_en(rx_en),
    .rx_lane_valid(tx_lane_valid), .rx_lane_byte(rx_lane_byte),
    .rx_back_out(rx_back_out), .push_valid(push_valid), .push_data(push_data)
  );

  always #5 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  int fed = 0, got = 0, naks = 0, inj = 0, lane_cycles = 0;
  int corrupt_pct = 0;
  bit toggle_en = 1'b0, force_crc = 1'b0;
  logic [DATA_W-1:0] words [0:63];

  function automatic logic [15:0] ref_crc(input logic [DATA_W-1:0] w);
    logic [15:0] c = 16'hFFFF;
    for (int b = NB - 1; b >= 0; b--) begin
      logic [7:0] d = w[b*8 +: 8];
      for (int i = 7; i >= 0; i--) begin
        if (c[15] ^ d[i]) c = (c << 1) ^ 16'h1021;
        else              c = c << 1;
      end
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  // word stream feeder (R9)
  initial begin
    forever begin
      bit t;
      @(negedge clk);
      wd_data = words[fed[5:0]];
      t = wd_ready;
      @(posedge clk);
      if (t) fed++;
    end
  end

  // reverse lane and push monitor (R6, R7)
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && rx_back_out == 2'd2) naks++;
      if (!rst && push_valid) begin
        chk(push_data == words[got[5:0]], "R7 push order", push_data, words[got[5:0]]);
        chk(rx_back_out == 2'd1, "R6 push with ACK", DATA_W'(rx_back_out), DATA_W'(1));
        got++;
      end
    end
  end

  // packet monitor and corruptor (R2, R3)
  initial begin
    int pos = 0, target = 0;
    bit corrupt = 1'b0;
    logic [7:0] pk [0:PKT-1];
    forever begin
      @(negedge clk);
      if (tx_lane_valid) begin
        lane_cycles++;
        if (pos == 0) begin
          if (force_crc) begin
            corrupt = 1'b1; target = PKT - 2; force_crc = 1'b0;
          end else begin
            corrupt = (($urandom % 100) < corrupt_pct);
            target  = 1 + ($urandom % (PKT - 1));
          end
          if (corrupt) inj++;
        end
        flip = (corrupt && pos == target) ? 8'(1 + ($urandom % 255)) : 8'h00;
        pk[pos] = tx_lane_byte;
        if (pos == PKT - 1) begin
          logic [DATA_W-1:0] w;
          logic [15:0] c, e;
          w = '0;
          for (int i = 1; i <= NB; i++) w = {w[DATA_W-9:0], pk[i]};
          c = {pk[PKT-2], pk[PKT-1]};
          e = ref_crc(words[got[5:0]]);
          chk(pk[0] == 8'hA5, "R2 marker", DATA_W'(pk[0]), DATA_W'(8'hA5));
          chk(w == words[got[5:0]], "R2 data bytes", w, words[got[5:0]]);
          chk(c == e, "R3 crc", DATA_W'(c), DATA_W'(e));
          pos = 0;
        end else begin
          pos++;
        end
      end else begin
        if (pos != 0) chk(1'b0, "R2 packet gap", DATA_W'(pos), DATA_W'(PKT));
        pos = 0;
        flip = 8'h00;
      end
    end
  end

  // random reception enable (R5)
  initial begin
    forever begin
      @(negedge clk);
      if (toggle_en && ($urandom % 100) < 15) rx_en = ~rx_en;
    end
  end

  task automatic run_block(input int n, input int pct, input bit tog);
    int b_got = got, b_fed = fed, b_nak = naks, b_inj = inj, w = 0;
    corrupt_pct = pct;
    toggle_en = tog;
    @(negedge clk);
    cmd_len = LEN_W'(n);
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    if (n == 0) chk(done == 1'b1, "R8 zero length done", DATA_W'(done), DATA_W'(1));
    else        chk(done == 1'b0, "R8 done cleared", DATA_W'(done), DATA_W'(0));
    while (!done && w < 20000) begin
      @(negedge clk);
      w++;
    end
    toggle_en = 1'b0;
    rx_en = 1'b1;
    chk(done == 1'b1, "R8 done at end", DATA_W'(done), DATA_W'(1));
    chk(got - b_got == n, "R7 words delivered", DATA_W'(got - b_got), DATA_W'(n));
    chk(fed - b_fed == n, "R9 words fetched", DATA_W'(fed - b_fed), DATA_W'(n));
    chk(naks - b_nak == inj - b_inj, "R4 naks vs corruptions",
        DATA_W'(naks - b_nak), DATA_W'(inj - b_inj));
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++)
      words[i] = {$urandom, $urandom, $urandom, $urandom};
    words[0] = '0;
    words[1] = '1;
    repeat (4) @(negedge clk);
    chk(tx_lane_valid == 1'b0, "R1 lane idle in reset", DATA_W'(tx_lane_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(tx_lane_valid == 1'b0, "R1 lane idle", DATA_W'(tx_lane_valid), 0);
    chk(push_valid == 1'b0, "R1 no push", DATA_W'(push_valid), 0);
    chk(done == 1'b0, "R1 done low", DATA_W'(done), 0);
    chk(wd_ready == 1'b0, "R1 wd_ready low", DATA_W'(wd_ready), 0);
    chk(rx_back_out == 2'd0, "R1 back idle", DATA_W'(rx_back_out), 0);

    // clean block
    rx_en = 1'b1;
    run_block(6, 0, 1'b0);
    // zero-length block
    run_block(0, 0, 1'b0);
    // forced corruption of the checksum byte
    force_crc = 1'b1;
    run_block(2, 0, 1'b0);
    // reception disabled: sender must stall (R5)
    rx_en = 1'b0;
    repeat (3) @(negedge clk);
    begin
      int lc0, g0;
      lc0 = lane_cycles;
      g0 = got;
      cmd_len = LEN_W'(3);
      cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
      repeat (60) @(negedge clk);
      chk(lane_cycles == lc0, "R5 no send while disabled", DATA_W'(lane_cycles - lc0), 0);
      chk(got == g0, "R5 no delivery while disabled", DATA_W'(got - g0), 0);
      chk(done == 1'b0, "R5 done held low", DATA_W'(done), 0);
      rx_en = 1'b1;
      while (!done && cyc < 140000) @(negedge clk);
      chk(got - g0 == 3, "R5 delivery after enable", DATA_W'(got - g0), 3);
    end
    // random corruption and random enable toggling
    run_block(20, 30, 1'b1);
    run_block(5, 60, 1'b0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule